// File: doc/BRIEF.md
# One-Second Latched Alarm Status

This block holds two banks of alarm and status bits that a host reads over a simple read port. Live status conditions arrive from line and framing logic. Each bank has its own hold enable. With the enable cleared, a read shows the live bits. With the enable set, alarms are gathered over an interval. An interval runs from one rising edge of an external one-second reference to the next. The gathered alarms are then kept for the host.

An alarm seen at any cycle in an interval is ORed into an accumulator. On the rising edge that closes the interval, the accumulator moves into a held register, together with any held bits the host has not yet read. The first read in an interval returns the held bits and clears them. A second read in the same interval returns the live state and discards what has gathered so far.

The counter-status bank has one bit, the line code violation indication, that is never held and always reads live. The one-second reference is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector, and both banks share the result. Each bank's read strobe marks one register read and also acts as its clear-on-read.

Top module: `alarm_sec_latch`

## Requirements
- R1: While a bank's hold enable is 0, its read data equals its live status input in the same cycle. The bank gathers nothing, so alarms seen while disabled never show up after the enable is set.
- R2: With the enable set, a bit that is high on the status input for even one clock in an interval reads as 1 on the first read in the next interval.
- R3: Held bits that are not read stay held across any number of later interval edges. New alarms are ORed into them.
- R4: The first read in an interval returns the held bits and clears them. A first read in a later interval then returns only alarms that occurred after that read.
- R5: A second read in the same interval returns the live status. Alarms gathered in that interval up to and including the read cycle are discarded.
- R6: An interval edge happens only on a rising edge of the one-second input, two clocks after the synchronizer samples it. Holding the input high does not start further intervals.
- R7: In the counter bank, the bit at position LCV_POS always reads live and is never held.
- R8: If a read falls in the same cycle as an interval edge, it returns the value from before the edge. The new interval's data is loaded afterwards, and the next read counts as the first read of the new interval.
- R9: The two banks have separate enables, read strobes and state. A read or an enable setting on one bank does not change the other.
- R10: After reset both banks hold nothing, so a first read with idle inputs returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-second reference, asynchronous |
| cnt_hold_en_i | input | 1 | Hold enable for the counter-status bank |
| line_hold_en_i | input | 1 | Hold enable for the line-status bank |
| cnt_stat_i | input | CNT_W | Live counter-status alarms |
| line_stat_i | input | LINE_W | Live line-status alarms |
| cnt_rd_i | input | 1 | Read strobe and clear-on-read for the counter bank |
| line_rd_i | input | 1 | Read strobe and clear-on-read for the line bank |
| cnt_rdata_o | output | CNT_W | Counter bank read data |
| line_rdata_o | output | LINE_W | Line bank read data |

## Verification
The assertions assume that the one-second reference changes far more slowly than the clock, so synchronized edges arrive at least one clock apart. They also assume that a read strobe is high for exactly one cycle for each register read. The stimulus holds the reference high and low for several clocks at a time and drives each strobe as a single-cycle pulse. The stimulus changes inputs one time unit after a rising clock edge, so every input is stable when the design and the reference model sample it.

// File: rtl/alarm_sec_pkg.sv
`timescale 1ns/1ps
package alarm_sec_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    RD_LIVE  = 2'd0,
    RD_HELD  = 2'd1,
    RD_FRESH = 2'd2
  } rd_src_e;
endpackage

// File: rtl/alarm_sec_tick.sv
`timescale 1ns/1ps
module alarm_sec_tick #(
  parameter int unsigned DEPTH = alarm_sec_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic edge_o
);
  localparam int unsigned LEN = DEPTH + 1;

  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[LEN-2:0], tick_i};
  end

  // last sync stage high, previous copy low
  assign edge_o = sr_q[DEPTH-1] & ~sr_q[DEPTH];
endmodule

// File: rtl/alarm_sec_hold.sv
`timescale 1ns/1ps
module alarm_sec_hold
  import alarm_sec_pkg::*;
#(
  parameter int unsigned   W         = 8,
  parameter logic [W-1:0]  LIVE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         rd_i,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] rdata_o
);
  localparam logic [W-1:0] HOLD_MASK = ~LIVE_MASK;

  logic [W-1:0] acc_q, held_q;
  logic         seen_q;
  logic [W-1:0] held_keep, acc_nx;
  rd_src_e      src;

  always_comb begin
    held_keep = (rd_i && !seen_q) ? '0 : held_q;
    acc_nx    = (rd_i && seen_q) ? '0 : (acc_q | (stat_i & HOLD_MASK));
    if (!en_i)       src = RD_LIVE;
    else if (seen_q) src = RD_FRESH;
    else             src = RD_HELD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      held_q <= '0;
      seen_q <= 1'b0;
    end else if (!en_i) begin
      acc_q  <= '0;
      held_q <= '0;
      seen_q <= 1'b0;
    end else if (tick_i) begin
      held_q <= held_keep | acc_nx;
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      held_q <= held_keep;
      acc_q  <= acc_nx;
      seen_q <= seen_q | rd_i;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (LIVE_MASK[b]) begin : g_live
      assign rdata_o[b] = stat_i[b];
    end else begin : g_held
      assign rdata_o[b] = (src == RD_HELD) ? held_q[b] : stat_i[b];
    end
  end
endmodule

// File: rtl/alarm_sec_latch.sv
`timescale 1ns/1ps
module alarm_sec_latch #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned LINE_W  = 8,
  parameter int unsigned LCV_POS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              cnt_hold_en_i,
  input  logic              line_hold_en_i,
  input  logic [CNT_W-1:0]  cnt_stat_i,
  input  logic [LINE_W-1:0] line_stat_i,
  input  logic              cnt_rd_i,
  input  logic              line_rd_i,
  output logic [CNT_W-1:0]  cnt_rdata_o,
  output logic [LINE_W-1:0] line_rdata_o
);
  localparam logic [CNT_W-1:0]  CNT_LIVE  = {{(CNT_W-1){1'b0}}, 1'b1} << LCV_POS;
  localparam logic [LINE_W-1:0] LINE_LIVE = '0;

  logic tick_edge;

  alarm_sec_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (sec_tick_i),
    .edge_o (tick_edge)
  );

  alarm_sec_hold #(.W(CNT_W), .LIVE_MASK(CNT_LIVE)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_hold_en_i),
    .tick_i  (tick_edge),
    .rd_i    (cnt_rd_i),
    .stat_i  (cnt_stat_i),
    .rdata_o (cnt_rdata_o)
  );

  alarm_sec_hold #(.W(LINE_W), .LIVE_MASK(LINE_LIVE)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (line_hold_en_i),
    .tick_i  (tick_edge),
    .rd_i    (line_rd_i),
    .stat_i  (line_stat_i),
    .rdata_o (line_rdata_o)
  );
endmodule

// File: rtl/alarm_sec_hold_chk.sv
`timescale 1ns/1ps
module alarm_sec_hold_chk #(
  parameter int unsigned  W         = 8,
  parameter logic [W-1:0] LIVE_MASK = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         tick_i,
  input logic         rd_i,
  input logic [W-1:0] stat_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] held_q,
  input logic         seen_q
);
  AST_OFF_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> rdata_o == stat_i);  // R1
  AST_OFF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (held_q == '0) && !seen_q);  // R1
  AST_HELD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !rd_i && !tick_i |=> !en_i || ((held_q & $past(held_q)) == $past(held_q)));  // R3
  AST_FIRST_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rd_i && !seen_q && !tick_i |=> !en_i || (held_q == '0));  // R4
  AST_RD_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rd_i && !tick_i |=> !en_i || seen_q);  // R5
  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);  // R6
  AST_MASK_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o ^ stat_i) & LIVE_MASK) == '0);  // R7
  AST_MASK_UNHELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q & LIVE_MASK) == '0);  // R7
  AST_SEEN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i |=> !en_i || !seen_q);  // R8
endmodule

bind alarm_sec_hold alarm_sec_hold_chk #(.W(W), .LIVE_MASK(LIVE_MASK)) u_hold_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .tick_i  (tick_i),
  .rd_i    (rd_i),
  .stat_i  (stat_i),
  .rdata_o (rdata_o),
  .held_q  (held_q),
  .seen_q  (seen_q)
);

// File: tb/alarm_sec_latch_bench.sv
`timescale 1ns/1ps
module alarm_sec_latch_bench;
  localparam int W = 4;
  localparam logic [W-1:0] CMASK = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, c_en = 1'b0, l_en = 1'b0, c_rd = 1'b0, l_rd = 1'b0;
  logic [W-1:0] c_stat = '0, l_stat = '0;
  logic [W-1:0] c_rdata, l_rdata;

  int n_chk = 0, n_fail = 0, cyc_chk = 0, cyc_fail = 0;
  logic wd_fail = 1'b0;

  always #2 clk = ~clk;

  alarm_sec_latch #(.CNT_W(W), .LINE_W(W), .LCV_POS(0)) u_alarm_sec_latch (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick),
    .cnt_hold_en_i(c_en), .line_hold_en_i(l_en),
    .cnt_stat_i(c_stat), .line_stat_i(l_stat),
    .cnt_rd_i(c_rd), .line_rd_i(l_rd),
    .cnt_rdata_o(c_rdata), .line_rdata_o(l_rdata)
  );

  // reference model built from the requirements
  logic [2:0] m_sr = '0;
  logic [W-1:0] mc_acc = '0, mc_held = '0, ml_acc = '0, ml_held = '0;
  logic mc_seen = 1'b0, ml_seen = 1'b0;
  logic m_edge_nxt;
  assign m_edge_nxt = m_sr[1] & ~m_sr[2];

  task automatic upd(input logic en, input logic e, input logic rd,
                     input logic [W-1:0] stat, input logic [W-1:0] mask,
                     inout logic [W-1:0] acc, inout logic [W-1:0] held,
                     inout logic seen);
    logic [W-1:0] hk, an;
    if (!en) begin
      acc = '0; held = '0; seen = 1'b0;
    end else begin
      hk = (rd && !seen) ? '0 : held;
      an = (rd && seen) ? '0 : (acc | (stat & ~mask));
      if (e) begin held = hk | an; acc = '0; seen = 1'b0; end
      else   begin held = hk; acc = an; seen = seen | rd; end
    end
  endtask

  function automatic logic [W-1:0] m_exp(input logic en, input logic seen,
      input logic [W-1:0] held, input logic [W-1:0] stat, input logic [W-1:0] mask);
    if (!en || seen) return stat;
    return (held & ~mask) | (stat & mask);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr <= '0;
      mc_acc <= '0; mc_held <= '0; mc_seen <= 1'b0;
      ml_acc <= '0; ml_held <= '0; ml_seen <= 1'b0;
    end else begin : mdl
      logic e;
      logic [W-1:0] ca, ch, la, lh;
      logic cs, ls;
      e = m_sr[1] & ~m_sr[2];
      ca = mc_acc; ch = mc_held; cs = mc_seen;
      la = ml_acc; lh = ml_held; ls = ml_seen;
      upd(c_en, e, c_rd, c_stat, CMASK, ca, ch, cs);
      upd(l_en, e, l_rd, l_stat, '0, la, lh, ls);
      m_sr <= {m_sr[1:0], tick};
      mc_acc <= ca; mc_held <= ch; mc_seen <= cs;
      ml_acc <= la; ml_held <= lh; ml_seen <= ls;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cyc_chk = cyc_chk + 2;
      if (c_rdata !== m_exp(c_en, mc_seen, mc_held, c_stat, CMASK)) begin
        cyc_fail++;
        $display("FAIL R2 model cnt: actual %h expected %h", c_rdata,
                 m_exp(c_en, mc_seen, mc_held, c_stat, CMASK));
      end
      if (l_rdata !== m_exp(l_en, ml_seen, ml_held, l_stat, '0)) begin
        cyc_fail++;
        $display("FAIL R2 model line: actual %h expected %h", l_rdata,
                 m_exp(l_en, ml_seen, ml_held, l_stat, '0));
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd_both(input logic [W-1:0] ec, input logic [W-1:0] el, input string req);
    c_rd = 1'b1; l_rd = 1'b1;
    @(negedge clk);
    chk({req, " cnt"}, c_rdata, ec);
    chk({req, " line"}, l_rdata, el);
    @(posedge clk); #1;
    c_rd = 1'b0; l_rd = 1'b0;
  endtask

  task automatic pulse(input logic [W-1:0] cv, input logic [W-1:0] lv);
    c_stat = cv; l_stat = lv;
    cyc(1);
    c_stat = '0; l_stat = '0;
  endtask

  task automatic do_tick;
    tick = 1'b1; cyc(4);
    tick = 1'b0; cyc(4);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed",
             (n_chk + cyc_chk) - (n_fail + cyc_fail + int'(wd_fail)),
             n_chk + cyc_chk + int'(wd_fail));
  endtask

  initial begin
    #(4 * 150000);
    wd_fail = 1'b1;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    c_en = 1'b1; l_en = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R10: empty after reset
    rd_both(4'h0, 4'h0, "R10");
    cyc(1);

    // R1: disabled banks read live
    c_en = 1'b0; l_en = 1'b0;
    for (int v = 0; v < 16; v++) begin
      c_stat = 4'(v); l_stat = 4'(15 - v);
      @(negedge clk);
      chk("R1 cnt", c_rdata, 4'(v));
      chk("R1 line", l_rdata, 4'(15 - v));
      @(posedge clk); #1;
    end
    c_stat = '0; l_stat = '0;
    c_en = 1'b1; l_en = 1'b1;
    do_tick();
    rd_both(4'h0, 4'h0, "R1 none gathered");

    // R2: single-cycle alarm of every pattern shows next interval
    for (int a = 0; a < 16; a++) begin
      pulse(4'(a), 4'(a));
      cyc(2);
      do_tick();
      rd_both(4'(a) & ~CMASK, 4'(a), "R2");
    end

    // R4: cleared by the first read
    do_tick();
    rd_both(4'h0, 4'h0, "R4");

    // R3: unread bits survive edges and merge
    pulse(4'h5, 4'h5);
    do_tick(); do_tick();
    pulse(4'h2, 4'h2);
    do_tick();
    rd_both(4'h6, 4'h7, "R3");

    // R5: second read returns live and discards gathering
    pulse(4'h9, 4'h9);
    do_tick();
    rd_both(4'h8, 4'h9, "R5 first");
    c_stat = 4'h6; l_stat = 4'h6;
    cyc(3);
    rd_both(4'h6, 4'h6, "R5 second");
    c_stat = '0; l_stat = '0;
    do_tick();
    rd_both(4'h0, 4'h0, "R5 discarded");

    // R6: a held-high reference makes one interval edge
    pulse(4'h3, 4'h3);
    tick = 1'b1; cyc(5);
    rd_both(4'h2, 4'h3, "R6 first");
    pulse(4'h4, 4'h4);
    cyc(10);
    rd_both(4'h0, 4'h0, "R6 no second edge");
    tick = 1'b0; cyc(4);
    do_tick();
    rd_both(4'h0, 4'h0, "R6");

    // R8: read coinciding with an interval edge
    pulse(4'h6, 4'h6);
    do_tick();
    pulse(4'h1, 4'h1);
    cyc(2);
    tick = 1'b1;
    while (!m_edge_nxt) cyc(1);
    rd_both(4'h6, 4'h6, "R8 pre-edge value");
    tick = 1'b0; cyc(4);
    rd_both(4'h0, 4'h1, "R8 new interval");

    // R9: separate enables
    c_en = 1'b0;
    pulse(4'h5, 4'h5);
    do_tick();
    c_stat = 4'hA;
    rd_both(4'hA, 4'h5, "R9");
    c_stat = '0;
    c_en = 1'b1;
    do_tick();
    c_rd = 1'b1;
    @(negedge clk); chk("R9 cnt only", c_rdata, 4'h0);
    @(posedge clk); #1; c_rd = 1'b0;
    pulse(4'h0, 4'hC);
    do_tick();
    rd_both(4'h0, 4'hC, "R9 line untouched");

    // R7: violation bit is live only
    pulse(4'h1, 4'h0);
    do_tick();
    rd_both(4'h0, 4'h0, "R7 not held");
    c_stat = 4'h1;
    cyc(1);
    rd_both(4'h1, 4'h0, "R7 live");
    c_stat = '0;
    cyc(3);

    summary();
    $finish;
  end
endmodule